// File: doc/BRIEF.md
# Bus Error Machine-Check Router

This block sits beside a host bridge that joins a processor bus to a PCI bus. Six error event lines come in from detectors outside the block: processor address-bus time-out, processor data parity, PCI parity, PCI system error, PCI master abort signalled by the bridge, and PCI target abort received by the bridge. Each event sets a sticky status bit. Software clears the bit by writing 1 to it.

Each status bit is gated by its own machine-check enable and drives a machine-check line to one of four bus masters. The processor-bus errors go to whichever master owns the processor address bus at that moment. The PCI parity and system errors go to master 0 only. The two abort errors go to the master that started the failed PCI transaction. To make that possible, the block captures the initiator ID at each transaction start. When an abort is recorded, it copies that ID into a per-abort owner register.

The two processor-bus errors also have interrupt enables. These feed one level-sensitive interrupt request to an external interrupt controller. A 32-bit register port gives software read and write access to the status word and both enable words.

Top module: `bus_err_mchk_router`

## Requirements
- R1: After a synchronous active-low reset, the status word, both enable words, every machine-check output and the interrupt request all read 0.
- R2: A one-cycle event pulse sets its status bit. The bit then stays set until a register write to the status word carries 1 in that bit position. Writing 0 has no effect. If an event and its clear arrive in the same cycle, the bit stays set.
- R3: The word address selects the register: 0 is status (write 1 to clear), 1 is machine-check enable, 2 is interrupt enable, and 3 reads 0. The bit positions are: 0 address time-out, 1 data parity, 2 PCI parity, 3 PCI system error, 4 master abort, 5 target abort. The machine-check enable implements bits 5:0 and the interrupt enable implements bits 1:0. All other bits read 0.
- R4: When the address time-out bit or the data parity bit is set with its machine-check enable, machine check is asserted on the master currently given by `cur_master`. If ownership moves, the machine check follows it.
- R5: When the PCI parity bit or the PCI system error bit is set with its enable, machine check is asserted on master 0 and on no other master, whoever owns the bus.
- R6: When the master abort bit or the target abort bit is set with its enable, machine check is asserted on the master whose ID was captured by the most recent `txn_start` before that abort event. Later starts and later ownership changes do not move it.
- R7: An error whose machine-check enable bit is 0 never asserts any machine-check output.
- R8: `irq` is high exactly when the address time-out bit or the data parity bit is set together with its interrupt-enable bit. The PCI error bits never raise `irq`.
- R9: A machine-check output stays high for as long as any enabled status bit routed to it stays set. It falls in the cycle after the last such bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_evt | input | 6 | Error event pulses, in the status bit order |
| cur_master | input | 2 | Current owner of the processor address bus |
| txn_start | input | 1 | A PCI transaction starts this cycle |
| txn_init_id | input | 2 | Initiating master of the starting transaction |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| mchk | output | 4 | Machine-check line, one per master |
| irq | output | 1 | Interrupt request level |

## Verification
Events are injected one class at a time while bus ownership is held at a master other than 0. This shows apart the three routing kinds: current owner, fixed master 0, and captured initiator. Ownership is then moved while a processor-bus error is pending, which shows live routing apart from a latched one. A new transaction is started after an abort, which shows a captured owner apart from a live one. The remaining cases each isolate one piece of the logic:
- the same-cycle set and clear case, and a write of 0 to status, isolate the sticky logic;
- all errors raised with enables off isolate the gating;
- interrupt-enable patterns that do not match the set status bits show that the interrupt uses only its own two bits.

// File: rtl/errrt_pkg.sv
// Package: shared constants for the bus error machine-check router.
// Assumes: status bit order is fixed and visible to software.
package errrt_pkg;
    localparam int NUM_ERR   = 6;
    localparam int E_ADR_TMO = 0;
    localparam int E_DAT_PAR = 1;
    localparam int E_PCI_PAR = 2;
    localparam int E_PCI_SYS = 3;
    localparam int E_MST_ABT = 4;
    localparam int E_TGT_ABT = 5;
    localparam int NUM_IRQ   = 2;   // only bits 1:0 have interrupt enables

    typedef enum logic [1:0] {
        RA_STATUS = 2'd0,
        RA_MCHKEN = 2'd1,
        RA_IRQEN  = 2'd2,
        RA_NONE   = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/err_sticky.sv
// Module: sticky status register with write-1-to-clear.
// Assumes: set events are single-cycle pulses. A set wins over a same-cycle clear.
module err_sticky #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_evt,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] status
);
    // Hold status bits: clear by mask, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_mask) | set_evt;
    end

    for (genvar i = 0; i < W; i++) begin : g_chk
        AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
            set_evt[i] |=> status[i]); // R2
        AST_HOLD_NO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            (status[i] && !clr_mask[i]) |=> status[i]); // R2
    end
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (status == '0)); // R1
endmodule

// File: rtl/init_tracker.sv
// Module: captures the initiator of each PCI transaction at its start and
// latches it into a per-abort owner register when that abort is recorded.
// Assumes: one outstanding outbound transaction at a time.
module init_tracker #(
    parameter int MW   = 2,
    parameter int NABT = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     txn_start,
    input  logic [MW-1:0]            txn_id,
    input  logic [NABT-1:0]          abort_evt,
    output logic [NABT-1:0][MW-1:0]  owner
);
    logic [MW-1:0] held_id;

    // Keep the initiator of the transaction in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)         held_id <= '0;
        else if (txn_start) held_id <= txn_id;
    end

    for (genvar a = 0; a < NABT; a++) begin : g_own
        // Freeze the initiator for this abort class when the abort arrives.
        always_ff @(posedge clk) begin
            if (!rst_n)            owner[a] <= '0;
            else if (abort_evt[a]) owner[a] <= held_id;
        end
        AST_OWNER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            !abort_evt[a] |=> $stable(owner[a])); // R6
    end
endmodule

// File: rtl/mchk_router.sv
// Module: combinational routing of enabled status bits to per-master
// machine-check lines.
// Assumes: master 0 is the fixed target of PCI parity and system errors.
module mchk_router
    import errrt_pkg::*;
#(
    parameter int NM = 4,
    parameter int MW = 2
) (
    input  logic [NUM_ERR-1:0]   status,
    input  logic [NUM_ERR-1:0]   mchk_en,
    input  logic [MW-1:0]        cur_master,
    input  logic [1:0][MW-1:0]   abt_owner,
    output logic [NM-1:0]        mchk
);
    logic [NUM_ERR-1:0] live;
    assign live = status & mchk_en;

    for (genvar m = 0; m < NM; m++) begin : g_m
        logic to_cur, to_fix, to_abt;
        // Sum every enabled error whose target resolves to this master.
        always_comb begin
            to_cur = (cur_master == MW'(m)) && (live[E_ADR_TMO] || live[E_DAT_PAR]);
            to_fix = (m == 0) && (live[E_PCI_PAR] || live[E_PCI_SYS]);
            to_abt = (live[E_MST_ABT] && abt_owner[0] == MW'(m))
                  || (live[E_TGT_ABT] && abt_owner[1] == MW'(m));
            mchk[m] = to_cur || to_fix || to_abt;
        end
    end
endmodule

// File: rtl/bus_err_mchk_router.sv
// Module: top of the bus error machine-check router. Holds the enable
// registers, decodes the register port and ties the sub-blocks together.
// Assumes: the read path is combinational. Writes take effect at the next edge.
module bus_err_mchk_router
    import errrt_pkg::*;
#(
    parameter int NUM_MASTERS = 4,
    parameter int DW          = 32,
    parameter int AW          = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_ERR-1:0]             err_evt,
    input  logic [$clog2(NUM_MASTERS)-1:0] cur_master,
    input  logic                           txn_start,
    input  logic [$clog2(NUM_MASTERS)-1:0] txn_init_id,
    input  logic                           reg_wr,
    input  logic [AW-1:0]                  reg_addr,
    input  logic [DW-1:0]                  reg_wdata,
    output logic [DW-1:0]                  reg_rdata,
    output logic [NUM_MASTERS-1:0]         mchk,
    output logic                           irq
);
    localparam int MW = $clog2(NUM_MASTERS);

    logic [NUM_ERR-1:0]    status, mchk_en, clr_mask;
    logic [NUM_IRQ-1:0]    irq_en;
    logic [1:0][MW-1:0]    abt_owner;
    logic                  wr_stat, wr_men, wr_ien;

    // Decode the write strobes per register.
    always_comb begin
        wr_stat  = reg_wr && (reg_addr == AW'(RA_STATUS));
        wr_men   = reg_wr && (reg_addr == AW'(RA_MCHKEN));
        wr_ien   = reg_wr && (reg_addr == AW'(RA_IRQEN));
        clr_mask = wr_stat ? reg_wdata[NUM_ERR-1:0] : '0;
    end

    // Hold the two enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mchk_en <= '0;
            irq_en  <= '0;
        end else begin
            if (wr_men) mchk_en <= reg_wdata[NUM_ERR-1:0];
            if (wr_ien) irq_en  <= reg_wdata[NUM_IRQ-1:0];
        end
    end

    // Select read data, zero-extending the implemented bits.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            AW'(RA_STATUS): reg_rdata[NUM_ERR-1:0] = status;
            AW'(RA_MCHKEN): reg_rdata[NUM_ERR-1:0] = mchk_en;
            AW'(RA_IRQEN):  reg_rdata[NUM_IRQ-1:0] = irq_en;
            default:        reg_rdata = '0;
        endcase
    end

    err_sticky #(.W(NUM_ERR)) u_stat (
        .clk(clk), .rst_n(rst_n), .set_evt(err_evt),
        .clr_mask(clr_mask), .status(status)
    );

    init_tracker #(.MW(MW), .NABT(2)) u_trk (
        .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_id(txn_init_id),
        .abort_evt(err_evt[E_TGT_ABT:E_MST_ABT]), .owner(abt_owner)
    );

    mchk_router #(.NM(NUM_MASTERS), .MW(MW)) u_rt (
        .status(status), .mchk_en(mchk_en), .cur_master(cur_master),
        .abt_owner(abt_owner), .mchk(mchk)
    );

    // Raise the interrupt level from the processor-bus errors only.
    assign irq = |(status[NUM_IRQ-1:0] & irq_en);

    AST_NO_MCHK_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (mchk_en == '0) |-> (mchk == '0)); // R7
    AST_IRQ_OFF_AFTER_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ien && reg_wdata[NUM_IRQ-1:0] == '0) |=> !irq); // R8
    AST_PCI_NOT_TO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (status[NUM_IRQ-1:0] == '0) |-> !irq); // R8
endmodule

// File: tb/tb_bus_err_mchk_router.sv
// Directed bench for the bus error machine-check router.
module tb_bus_err_mchk_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  err_evt = '0;
    logic [1:0]  cur_master = '0;
    logic        txn_start = 1'b0;
    logic [1:0]  txn_init_id = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  mchk;
    logic        irq;
    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    bus_err_mchk_router dut (
        .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .cur_master(cur_master),
        .txn_start(txn_start), .txn_init_id(txn_init_id), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mchk(mchk), .irq(irq)
    );

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic pulse(input logic [5:0] e);
        err_evt = e; step(); err_evt = '0;
    endtask

    task automatic clear_all();
        wr(2'd0, 32'hFFFF_FFFF); wr(2'd1, 32'h0); wr(2'd2, 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d); check("R1 reg after reset", d, 32'h0);
        end
        check("R1 mchk after reset", {28'h0, mchk}, 32'h0);
        check("R1 irq after reset", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_regmap();
        logic [31:0] d;
        wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, d); check("R3 mchk enable width", d, 32'h3F);
        wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, d); check("R3 irq enable width", d, 32'h3);
        rd(2'd3, d); check("R3 unused address", d, 32'h0);
        clear_all();
    endtask

    task automatic t_sticky();
        logic [31:0] d;
        pulse(6'b000100); rd(2'd0, d); check("R2 event sets bit2", d, 32'h4);
        step(); rd(2'd0, d); check("R2 bit holds", d, 32'h4);
        wr(2'd0, 32'h0); rd(2'd0, d); check("R2 write 0 ignored", d, 32'h4);
        err_evt = 6'b000100; wr(2'd0, 32'h4); err_evt = '0;
        rd(2'd0, d); check("R2 set wins over clear", d, 32'h4);
        wr(2'd0, 32'h4); rd(2'd0, d); check("R2 write 1 clears", d, 32'h0);
    endtask

    task automatic t_cur_master();
        wr(2'd1, 32'h3F);
        cur_master = 2'd2;
        pulse(6'b000001); check("R4 time-out to owner 2", {28'h0, mchk}, 32'h4);
        cur_master = 2'd3; #1; check("R4 follows ownership", {28'h0, mchk}, 32'h8);
        pulse(6'b000010); wr(2'd0, 32'h1);
        check("R9 held by data parity", {28'h0, mchk}, 32'h8);
        wr(2'd0, 32'h2); check("R9 drops after clear", {28'h0, mchk}, 32'h0);
        clear_all();
    endtask

    task automatic t_pci_fixed();
        wr(2'd1, 32'h3F); cur_master = 2'd2;
        pulse(6'b001000); check("R5 system error to master 0", {28'h0, mchk}, 32'h1);
        wr(2'd0, 32'h8);
        pulse(6'b000100); check("R5 parity to master 0", {28'h0, mchk}, 32'h1);
        clear_all();
    endtask

    task automatic t_abort();
        wr(2'd1, 32'h3F); cur_master = 2'd1;
        txn_start = 1'b1; txn_init_id = 2'd3; step(); txn_start = 1'b0;
        pulse(6'b010000); check("R6 master abort to initiator 3", {28'h0, mchk}, 32'h8);
        txn_start = 1'b1; txn_init_id = 2'd2; step(); txn_start = 1'b0;
        check("R6 later start keeps owner", {28'h0, mchk}, 32'h8);
        pulse(6'b100000); check("R6 target abort to initiator 2", {28'h0, mchk}, 32'hC);
        clear_all();
    endtask

    task automatic t_disabled();
        logic [31:0] d;
        wr(2'd1, 32'h0); cur_master = 2'd0;
        pulse(6'b111111); rd(2'd0, d); check("R7 status all set", d, 32'h3F);
        check("R7 no mchk when disabled", {28'h0, mchk}, 32'h0);
        wr(2'd1, 32'h0C); check("R7 only enabled PCI bits", {28'h0, mchk}, 32'h1);
        clear_all();
    endtask

    task automatic t_irq();
        pulse(6'b111110);
        wr(2'd2, 32'h1); check("R8 mismatch enable no irq", {31'h0, irq}, 32'h0);
        wr(2'd2, 32'h2); check("R8 data parity irq", {31'h0, irq}, 32'h1);
        wr(2'd0, 32'h2); check("R8 PCI bits no irq", {31'h0, irq}, 32'h0);
        pulse(6'b000001); wr(2'd2, 32'h1); check("R8 time-out irq", {31'h0, irq}, 32'h1);
        clear_all();
    endtask

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_regmap();
        t_sticky();
        t_cur_master();
        t_pci_fixed();
        t_abort();
        t_disabled();
        t_irq();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule